// File: doc/BRIEF.md
# E3 Receive Performance Error Monitor

This block sits behind the frame aligner on the receive side of an E3 line carrying a G.832-style frame. Each accepted byte arrives with a strobe marking the first byte of a frame and strobes marking the two overhead bytes it cares about. The first of these holds the parity reference and the second holds the remote error bit. For every frame the block computes an 8-bit interleaved parity over all accepted bytes. It compares that value with the reference byte carried one frame later. It also counts framing errors reported by the aligner and remote error indications signalled by the far end.

Three 16-bit counters collect parity, framing and remote errors. They stop at all ones instead of wrapping. A host takes a snapshot with a one-cycle strobe: the live counts move into holding registers and the counters restart from zero in the same cycle. Two configuration pins choose the parity counting mode and decide whether counting is held off while the aligner reports loss of frame or an alarm signal.

The byte input uses a valid/ready handshake. The block never applies back-pressure: ready is low only during reset and the cycle after it, and is high from then on. A byte is taken only in a cycle where valid and ready are both high. Every strobe and sideband flag is read only on such a cycle. Upstream logic may hold valid low for any number of cycles between bytes.

Top module: `e3_perf_mon`

## Requirements
- R1: `in_ready` is low while `rst` is high and on the first cycle after it, then stays high. A byte and its strobes and flags take effect only in a cycle with `in_valid` and `in_ready` both high; in any other cycle no counter changes.
- R2: The parity of a frame is the XOR of every accepted byte from one `in_sof` byte up to the byte before the next `in_sof` byte. It is compared with the byte flagged by `in_em` in the following frame. `in_em` and `in_ma` are never set on an `in_sof` byte. The frame that follows reset has no reference and its `in_em` byte is not checked.
- R3: With `cfg_bip_bits` = 0, a checked frame whose reference byte differs from the computed parity adds exactly 1 to the parity count.
- R4: With `cfg_bip_bits` = 1, a checked frame adds the number of differing bit positions (0 to 8) to the parity count.
- R5: `in_frm_err` is read on the `in_sof` byte only. When set, it adds 1 to the framing count.
- R6: Bit 3 of the byte flagged by `in_ma` (bit 7 is the MSB) is the remote error bit. Each such byte with the bit set adds 1 to the remote count.
- R7: With `cfg_ungated` = 0, a framing error is not counted when `in_oof` or `in_ais` is high on that `in_sof` byte.
- R8: The alarm state of a frame is `in_oof`|`in_ais` sampled on its `in_sof` byte. With `cfg_ungated` = 0, parity and remote errors are not counted in a frame whose alarm state is set, or whose previous frame's alarm state was set.
- R9: With `cfg_ungated` = 1, all three counts advance whatever the alarm states are.
- R10: Each count stops at 65535 and does not wrap.
- R11: A cycle with `lat_stb` high copies the three live counts into `hold_fe`, `hold_pe` and `hold_rei` at the next edge. The live counts restart from the increment of that same cycle, so an error that coincides with the strobe goes into the new period.
- R12: After reset all holding outputs read 0 and all live counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte valid |
| in_ready | output | 1 | Byte ready, low only around reset |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_em | input | 1 | Byte is the parity reference byte |
| in_ma | input | 1 | Byte carries the remote error bit (bit 3) |
| in_frm_err | input | 1 | Framing error flag for the frame, read on the `in_sof` byte |
| in_oof | input | 1 | Loss-of-frame state, read on the `in_sof` byte |
| in_ais | input | 1 | Alarm signal state, read on the `in_sof` byte |
| cfg_bip_bits | input | 1 | 0: one count per errored frame, 1: one count per errored bit |
| cfg_ungated | input | 1 | 1: count even while alarms are present |
| lat_stb | input | 1 | Snapshot strobe: copy counts and restart them |
| hold_fe | output | 16 | Framing error count from the last snapshot |
| hold_pe | output | 16 | Parity error count from the last snapshot |
| hold_rei | output | 16 | Remote error count from the last snapshot |

## Verification
The bench checks that the reference byte of the first frame after reset is ignored. A design that checked it would count one extra error. It checks the frame in which an alarm clears: a design that looked only at the current alarm state would count that frame's parity and remote errors, while correct framing errors there must still be counted. It places a snapshot strobe on the same cycle as a parity error, where a design that cleared the counter after adding would lose that error. It drives bit-mode errors past 65535, where a wrapping counter would read back a small number. Idle cycles with `in_valid` low carry random strobes and flags, so a design that did not qualify its inputs with the handshake would corrupt the parity and the counts.

// File: rtl/e3pm_pkg.sv
package e3pm_pkg;
  localparam int NUM_CNT = 3;
  localparam int IDX_FRM = 0;
  localparam int IDX_PAR = 1;
  localparam int IDX_REI = 2;

  typedef struct packed {
    logic cur;
    logic prev;
  } alarm_hist_t;
endpackage

// File: rtl/e3pm_bip.sv
module e3pm_bip #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          sof,
  input  logic          em,
  input  logic [DW-1:0] data,
  output logic          chk_vld,
  output logic [DW-1:0] diff
);
  logic [DW-1:0] acc_q;
  logic [DW-1:0] ref_q;
  logic          seen_q;
  logic          ref_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      ref_q    <= '0;
      seen_q   <= 1'b0;
      ref_ok_q <= 1'b0;
    end else if (fire) begin
      if (sof) begin
        ref_q    <= acc_q;
        ref_ok_q <= seen_q;
        seen_q   <= 1'b1;
        acc_q    <= data;
      end else begin
        acc_q <= acc_q ^ data;
      end
    end
  end

  // reference byte of this frame checked against last frame's parity
  assign chk_vld = fire & em & ~sof & ref_ok_q;
  assign diff    = ref_q ^ data;
endmodule

// File: rtl/e3pm_gate.sv
module e3pm_gate
  import e3pm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic sof,
  input  logic oof,
  input  logic ais,
  input  logic ungated,
  output logic frm_ok,
  output logic win_ok
);
  alarm_hist_t hist_q;
  logic        alarm_now;

  assign alarm_now = oof | ais;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (fire && sof) begin
      hist_q.prev <= hist_q.cur;
      hist_q.cur  <= alarm_now;
    end
  end

  // framing flag judged on the alarm state seen with the same byte
  assign frm_ok = ungated | ~alarm_now;
  // parity and remote errors need a clean frame after a clean frame
  assign win_ok = ungated | ~(hist_q.cur | hist_q.prev);
endmodule

// File: rtl/e3pm_satcnt.sv
module e3pm_satcnt #(
  parameter int CW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lat,
  input  logic [IW-1:0] inc,
  output logic [CW-1:0] live,
  output logic [CW-1:0] hold
);
  logic [CW-1:0] base;
  logic [CW:0]   sum;
  logic [CW-1:0] nxt;

  always_comb begin
    base = lat ? '0 : live;
    sum  = {1'b0, base} + {{(CW + 1 - IW){1'b0}}, inc};
    nxt  = sum[CW] ? '1 : sum[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      hold <= '0;
    end else begin
      live <= nxt;
      if (lat) hold <= live;
    end
  end
endmodule

// File: rtl/e3_perf_mon.sv
module e3_perf_mon
  import e3pm_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 16,
  parameter int REI_POS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_em,
  input  logic              in_ma,
  input  logic              in_frm_err,
  input  logic              in_oof,
  input  logic              in_ais,
  input  logic              cfg_bip_bits,
  input  logic              cfg_ungated,
  input  logic              lat_stb,
  output logic [CNT_W-1:0]  hold_fe,
  output logic [CNT_W-1:0]  hold_pe,
  output logic [CNT_W-1:0]  hold_rei
);
  localparam int INC_W = $clog2(DATA_W + 1);

  logic              rdy_q;
  logic              fire;
  logic              chk_vld;
  logic [DATA_W-1:0] diff;
  logic              frm_ok;
  logic              win_ok;
  logic [INC_W-1:0]  pc;
  logic [INC_W-1:0]  inc_v  [NUM_CNT];
  logic [CNT_W-1:0]  live_v [NUM_CNT];
  logic [CNT_W-1:0]  hold_v [NUM_CNT];
  logic [CNT_W-1:0]  live_fe;
  logic [CNT_W-1:0]  live_pe;
  logic [CNT_W-1:0]  live_rei;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign fire     = in_valid & rdy_q;

  e3pm_bip #(.DW(DATA_W)) u_bip (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .sof     (in_sof),
    .em      (in_em),
    .data    (in_data),
    .chk_vld (chk_vld),
    .diff    (diff)
  );

  e3pm_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .sof     (in_sof),
    .oof     (in_oof),
    .ais     (in_ais),
    .ungated (cfg_ungated),
    .frm_ok  (frm_ok),
    .win_ok  (win_ok)
  );

  always_comb begin
    pc = '0;
    for (int i = 0; i < DATA_W; i++) pc = pc + INC_W'(diff[i]);
  end

  always_comb begin
    inc_v[IDX_FRM] = INC_W'(fire & in_sof & in_frm_err & frm_ok);
    inc_v[IDX_PAR] = '0;
    if (chk_vld && win_ok)
      inc_v[IDX_PAR] = cfg_bip_bits ? pc : INC_W'(|diff);
    inc_v[IDX_REI] = INC_W'(fire & in_ma & ~in_sof & in_data[REI_POS] & win_ok);
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    e3pm_satcnt #(.CW(CNT_W), .IW(INC_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .lat  (lat_stb),
      .inc  (inc_v[g]),
      .live (live_v[g]),
      .hold (hold_v[g])
    );
  end

  assign live_fe  = live_v[IDX_FRM];
  assign live_pe  = live_v[IDX_PAR];
  assign live_rei = live_v[IDX_REI];
  assign hold_fe  = hold_v[IDX_FRM];
  assign hold_pe  = hold_v[IDX_PAR];
  assign hold_rei = hold_v[IDX_REI];
endmodule

// File: rtl/e3pm_chk.sv
module e3pm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sof,
  input logic             in_oof,
  input logic             in_ais,
  input logic             cfg_bip_bits,
  input logic             cfg_ungated,
  input logic             lat_stb,
  input logic [CNT_W-1:0] live_fe,
  input logic [CNT_W-1:0] live_pe,
  input logic [CNT_W-1:0] live_rei,
  input logic [CNT_W-1:0] hold_fe,
  input logic [CNT_W-1:0] hold_pe,
  input logic [CNT_W-1:0] hold_rei
);
  assert_ready_stays_R1: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready);

  assert_idle_no_count_R1: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && in_ready) && !lat_stb) |=>
      ($stable(live_fe) && $stable(live_pe) && $stable(live_rei)));

  assert_block_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_bip_bits && !lat_stb) |=>
      ((live_pe >= $past(live_pe)) && ((live_pe - $past(live_pe)) <= CNT_W'(1))));

  assert_bit_step_R4: assert property (@(posedge clk) disable iff (rst)
    !lat_stb |=>
      ((live_pe >= $past(live_pe)) && ((live_pe - $past(live_pe)) <= CNT_W'(8))));

  assert_frm_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_sof && (in_oof || in_ais) && !cfg_ungated && !lat_stb)
      |=> $stable(live_fe));

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    ((live_pe == '1) && !lat_stb) |=> (live_pe == '1));

  assert_snapshot_copy_R11: assert property (@(posedge clk) disable iff (rst)
    lat_stb |=> ((hold_fe == $past(live_fe)) && (hold_pe == $past(live_pe)) &&
                 (hold_rei == $past(live_rei))));

  assert_snapshot_restart_R11: assert property (@(posedge clk) disable iff (rst)
    lat_stb |=> ((live_fe <= CNT_W'(1)) && (live_pe <= CNT_W'(8)) &&
                 (live_rei <= CNT_W'(1))));
endmodule

bind e3_perf_mon e3pm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_sof       (in_sof),
  .in_oof       (in_oof),
  .in_ais       (in_ais),
  .cfg_bip_bits (cfg_bip_bits),
  .cfg_ungated  (cfg_ungated),
  .lat_stb      (lat_stb),
  .live_fe      (live_fe),
  .live_pe      (live_pe),
  .live_rei     (live_rei),
  .hold_fe      (hold_fe),
  .hold_pe      (hold_pe),
  .hold_rei     (hold_rei)
);

// File: tb/tb_e3_perf_mon.sv
module tb_e3_perf_mon;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0, in_em = 1'b0, in_ma = 1'b0;
  logic        in_frm_err = 1'b0, in_oof = 1'b0, in_ais = 1'b0;
  logic        cfg_bip_bits = 1'b0, cfg_ungated = 1'b0, lat_stb = 1'b0;
  logic [15:0] hold_fe, hold_pe, hold_rei;

  int total = 0;
  int bad   = 0;
  logic [7:0] tb_bip = '0;

  always #5 clk = ~clk;

  e3_perf_mon dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_em(in_em), .in_ma(in_ma),
    .in_frm_err(in_frm_err), .in_oof(in_oof), .in_ais(in_ais),
    .cfg_bip_bits(cfg_bip_bits), .cfg_ungated(cfg_ungated), .lat_stb(lat_stb),
    .hold_fe(hold_fe), .hold_pe(hold_pe), .hold_rei(hold_rei)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int         m_cnt [3];
  int         m_hold [3];
  int         m_inc [3];
  logic [7:0] m_acc, m_ref;
  bit         m_seen, m_refok, m_cur, m_prev, m_rdy, m_live;

  function automatic int sat(input int v);
    return (v > 65535) ? 65535 : v;
  endfunction

  always @(posedge clk) begin
    bit fire, ok, al;
    logic [7:0] d;
    if (rst) begin
      for (int k = 0; k < 3; k++) begin m_cnt[k] = 0; m_hold[k] = 0; end
      m_acc = '0; m_ref = '0; m_seen = 0; m_refok = 0;
      m_cur = 0; m_prev = 0; m_rdy = 0; m_live = 1;
    end else begin
      fire = in_valid && m_rdy;
      for (int k = 0; k < 3; k++) m_inc[k] = 0;
      if (fire && in_sof) begin
        al = in_oof || in_ais;
        if (in_frm_err && (cfg_ungated || !al)) m_inc[0] = 1;
        m_prev = m_cur; m_cur = al;
        m_ref = m_acc; m_refok = m_seen; m_seen = 1; m_acc = in_data;
      end else if (fire) begin
        ok = cfg_ungated || !(m_cur || m_prev);
        if (in_em && m_refok && ok) begin
          d = m_ref ^ in_data;
          m_inc[1] = cfg_bip_bits ? $countones(d) : int'(d != 0);
        end
        if (in_ma && ok && in_data[3]) m_inc[2] = 1;
        m_acc = m_acc ^ in_data;
      end
      for (int k = 0; k < 3; k++) begin
        if (lat_stb) begin
          m_hold[k] = m_cnt[k];
          m_cnt[k]  = sat(m_inc[k]);
        end else begin
          m_cnt[k] = sat(m_cnt[k] + m_inc[k]);
        end
      end
      m_rdy = 1;
    end
  end

  always @(negedge clk) begin
    if (m_live) begin
      chk("R1 ready", int'(in_ready), int'(m_rdy));
      chk("R5 model hold_fe", int'(hold_fe), m_hold[0]);
      chk("R3 model hold_pe", int'(hold_pe), m_hold[1]);
      chk("R6 model hold_rei", int'(hold_rei), m_hold[2]);
    end
  end

  task automatic send_frame(input logic [7:0] emask, input bit fe, input bit rei,
                            input bit oof, input bit ais, input int lat_at,
                            input bit gaps);
    logic [7:0] b [8];
    logic [7:0] acc;
    for (int i = 0; i < 8; i++) b[i] = 8'($urandom);
    b[2] = tb_bip ^ emask;
    b[3] = (b[3] & 8'hF7) | {4'b0, rei, 3'b0};
    acc = '0;
    for (int i = 0; i < 8; i++) acc = acc ^ b[i];
    for (int i = 0; i < 8; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        in_valid = 1'b0; in_data = 8'($urandom);
        in_sof = 1'($urandom); in_em = 1'($urandom); in_ma = 1'($urandom);
        in_frm_err = 1'b1; lat_stb = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = b[i];
      in_sof = (i == 0); in_em = (i == 2); in_ma = (i == 3);
      in_frm_err = (i == 0) ? fe : 1'($urandom);
      in_oof = oof; in_ais = ais;
      lat_stb = (i == lat_at);
    end
    tb_bip = acc;
  endtask

  task automatic do_latch();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_em = 1'b0; in_ma = 1'b0; lat_stb = 1'b1;
    @(negedge clk);
    lat_stb = 1'b0;
  endtask

  task automatic check_hold(input string tag, input int fe, input int pe, input int rei);
    chk({tag, " hold_fe"}, int'(hold_fe), fe);
    chk({tag, " hold_pe"}, int'(hold_pe), pe);
    chk({tag, " hold_rei"}, int'(hold_rei), rei);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_hold("R12 reset", 0, 0, 0);
    chk("R1 ready in reset", int'(in_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", int'(in_ready), 1);

    // R2: first frame unchecked; block mode R3; framing R5; remote R6
    send_frame(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b1);
    send_frame(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, -1, 1'b1);
    send_frame(8'h07, 1'b0, 1'b1, 1'b0, 1'b0, -1, 1'b1);
    do_latch();
    check_hold("R2 R3 R5 R6 block", 1, 1, 1);

    // R4: bit mode, 3 + 8 errored bits
    cfg_bip_bits = 1'b1;
    send_frame(8'h07, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b1);
    send_frame(8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b1);
    send_frame(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b1);
    do_latch();
    check_hold("R4 bit mode", 0, 11, 0);

    // R7 R8: gated counting around alarms
    cfg_bip_bits = 1'b0;
    send_frame(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b1);
    send_frame(8'h10, 1'b1, 1'b1, 1'b1, 1'b0, -1, 1'b1);
    send_frame(8'h10, 1'b1, 1'b1, 1'b0, 1'b0, -1, 1'b1);
    send_frame(8'h10, 1'b1, 1'b1, 1'b0, 1'b0, -1, 1'b1);
    send_frame(8'h10, 1'b1, 1'b1, 1'b0, 1'b1, -1, 1'b1);
    send_frame(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b1);
    send_frame(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b1);
    do_latch();
    check_hold("R7 R8 gated", 2, 1, 1);

    // R9: same pattern ungated
    cfg_ungated = 1'b1;
    send_frame(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b1);
    send_frame(8'h10, 1'b1, 1'b1, 1'b1, 1'b0, -1, 1'b1);
    send_frame(8'h10, 1'b1, 1'b1, 1'b0, 1'b0, -1, 1'b1);
    send_frame(8'h10, 1'b1, 1'b1, 1'b0, 1'b0, -1, 1'b1);
    send_frame(8'h10, 1'b1, 1'b1, 1'b0, 1'b1, -1, 1'b1);
    send_frame(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b1);
    send_frame(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b1);
    do_latch();
    check_hold("R9 ungated", 4, 4, 4);

    // R11: snapshot on the same cycle as a parity error
    cfg_ungated = 1'b0;
    send_frame(8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 2, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    check_hold("R11 coincident snapshot", 1, 0, 0);
    do_latch();
    check_hold("R11 error in new period", 0, 1, 0);

    // R10: saturation in bit mode
    cfg_bip_bits = 1'b1;
    cfg_ungated  = 1'b1;
    for (int f = 0; f < 8200; f++)
      send_frame(8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b0);
    do_latch();
    check_hold("R10 saturation", 0, 65535, 0);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule